// File: doc/BRIEF.md
# Round-Robin Dual Converter Scan Sequencer

This block walks an eight-entry conversion table in a fixed cycle, moving one entry on each periodic phase tick. It serves two external A/D converter sets through one shared 24-bit word. The lower 12-bit half of that word belongs to converter set 1 and the upper half belongs to converter set 2. Every table entry pairs a configuration word, which holds the channel selects, with a result word, which holds the captured readings. Each of those words is split the same way.

Capture and launch are pipelined on the same tick. The block first stores the converter reading taken from the channels chosen on the previous tick. It then writes the next entry's selects to the converters, and that write also starts the conversion. In each half, a 4-bit select value of 0–7 chooses that channel in unipolar mode. A value of 8–15 chooses channel (value − 8) in bipolar mode. The channel numbers for converter set 2 are offset by 8 at the board level, so that set covers inputs 8–15.

A host port reads and writes the configuration words and reads the result words. Each access is a single cycle.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, conv_wstb is 0 and conv_wdata is 0. Every configuration word and every result word reads back as 0.
- R2: The first tick after reset launches entry 0 and captures nothing, so all result words stay 0.
- R3: A tick in cycle N drives conv_wstb high in cycle N+1 for exactly one cycle. conv_wdata changes only together with a strobe and otherwise holds its value.
- R4: Every later tick does two things. It stores conv_rdata, sampled in the tick cycle, into the result word of the entry launched by the previous tick. It then launches the following entry.
- R5: The launched entry advances by one per tick and wraps from entry 7 back to entry 0.
- R6: Each 12-bit configuration half keeps only its bits 3:0, so the word keeps bits 3:0 and 15:12. Values 0–15 pass through unchanged, covering both the unipolar codes 0–7 and the bipolar codes 8–15. The other bits read back as 0 and are driven as 0 on conv_wdata.
- R7: host_addr[3] selects the region: 1 for results, 0 for configuration. host_addr[2:0] is the entry index. host_rdata shows the addressed word one cycle after the address is applied.
- R8: A host write to a result address (host_addr[3]=1) has no effect on any stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Phase tick, one-cycle pulse |
| host_addr | input | 4 | Bit 3 region select (1 = result), bits 2:0 entry index |
| host_we | input | 1 | Host write enable |
| host_wdata | input | 24 | Host write data |
| host_rdata | output | 24 | Registered host read data |
| conv_wdata | output | 24 | Select/start word to both converter sets |
| conv_wstb | output | 1 | One-cycle strobe that starts a conversion |
| conv_rdata | input | 24 | Converter readings, sampled on tick |

## Verification
The hardest case to reach is the pairing between a captured reading and the entry it belongs to. A reading presented on a tick belongs to the entry launched one tick earlier. Across the wrap it belongs to entry 7, and it is stored while entry 0 is being launched again.

The bench drives ten ticks, each with a distinct reading. That covers the empty first tick, a full lap of the table and the wrap. It then reads every result word back through the host port and compares it with a model that records which entry each tick launched.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int ENTRIES = 8,
  parameter int HALF_W  = 12,
  parameter int SEL_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [$clog2(ENTRIES):0] host_addr,
  input  logic                host_we,
  input  logic [2*HALF_W-1:0] host_wdata,
  output logic [2*HALF_W-1:0] host_rdata,
  output logic [2*HALF_W-1:0] conv_wdata,
  output logic                conv_wstb,
  input  logic [2*HALF_W-1:0] conv_rdata
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int PAD_W  = HALF_W - SEL_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [SEL_W-1:0]  sel_lo  [ENTRIES];
  logic [SEL_W-1:0]  sel_hi  [ENTRIES];
  logic [WORD_W-1:0] res_mem [ENTRIES];
  logic [IDX_W-1:0]  ptr;
  logic              started;

  wire [IDX_W-1:0] nxt   = !started ? '0 : (ptr == LAST) ? '0 : ptr + IDX_W'(1);
  wire [IDX_W-1:0] h_idx = host_addr[IDX_W-1:0];
  wire             h_res = host_addr[IDX_W];

  function automatic logic [WORD_W-1:0] cfg_word(input logic [SEL_W-1:0] hi,
                                                 input logic [SEL_W-1:0] lo);
    return {{PAD_W{1'b0}}, hi, {PAD_W{1'b0}}, lo};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        sel_lo[i]  <= '0;
        sel_hi[i]  <= '0;
        res_mem[i] <= '0;
      end
    end else begin
      if (host_we && !h_res) begin
        sel_lo[h_idx] <= host_wdata[SEL_W-1:0];
        sel_hi[h_idx] <= host_wdata[HALF_W+SEL_W-1:HALF_W];
      end
      if (tick && started)
        res_mem[ptr] <= conv_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr        <= '0;
      started    <= 1'b0;
      conv_wdata <= '0;
      conv_wstb  <= 1'b0;
    end else begin
      conv_wstb <= tick;
      if (tick) begin
        ptr        <= nxt;
        started    <= 1'b1;
        conv_wdata <= cfg_word(sel_hi[nxt], sel_lo[nxt]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) host_rdata <= '0;
    else        host_rdata <= h_res ? res_mem[h_idx] : cfg_word(sel_hi[h_idx], sel_lo[h_idx]);
  end
endmodule

module adc_scan_seq_chk #(
  parameter int ENTRIES = 8,
  parameter int HALF_W  = 12,
  parameter int SEL_W   = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tick,
  input logic                       conv_wstb,
  input logic [2*HALF_W-1:0]        conv_wdata,
  input logic [$clog2(ENTRIES)-1:0] ptr,
  input logic                       started
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  assert_strobe_follows_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> conv_wstb);
  assert_strobe_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_wstb |-> $past(tick));
  assert_word_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_wstb |-> $stable(conv_wdata));
  assert_pad_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_wdata[HALF_W-1:SEL_W] == '0 && conv_wdata[2*HALF_W-1:HALF_W+SEL_W] == '0);
  assert_first_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !started |=> started && ptr == '0);
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick && started && ptr == LAST |=> ptr == '0);
  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick && started && ptr != LAST |=> ptr == $past(ptr) + IDX_W'(1));
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ptr));
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.ENTRIES(ENTRIES), .HALF_W(HALF_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .conv_wstb(conv_wstb),
  .conv_wdata(conv_wdata), .ptr(ptr), .started(started));

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tick = 0;
  logic [3:0]  host_addr = '0;
  logic        host_we = 0;
  logic [23:0] host_wdata = '0;
  logic [23:0] host_rdata, conv_wdata, conv_rdata;
  logic        conv_wstb;
  int n_chk = 0, n_bad = 0;
  logic [23:0] exp_res [8];
  logic [23:0] exp_cfg [8];

  always #5 clk = ~clk;

  adc_scan_seq u_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .host_addr(host_addr), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .conv_wdata(conv_wdata),
    .conv_wstb(conv_wstb), .conv_rdata(conv_rdata));

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_read(input logic [3:0] a, output logic [23:0] d);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic host_write(input logic [3:0] a, input logic [23:0] d);
    host_addr = a; host_wdata = d; host_we = 1;
    @(negedge clk);
    host_we = 0;
  endtask

  function automatic logic [23:0] mask(logic [23:0] w);
    return {8'h0, w[15:12], 8'h0, w[3:0]};
  endfunction

  task automatic t_reset;
    logic [23:0] d;
    check("R1 strobe", {23'h0, conv_wstb}, 24'h0);
    check("R1 word", conv_wdata, 24'h0);
    for (int i = 0; i < 8; i++) begin
      host_read(4'(8 + i), d); check("R1 result", d, 24'h0);
      host_read(4'(i), d);     check("R1 config", d, 24'h0);
    end
  endtask

  task automatic t_config;
    logic [23:0] d;
    for (int i = 0; i < 8; i++) begin
      exp_cfg[i] = 24'hFFF000 ^ {4'h0, 4'(i + 8), 12'h0} ^ 24'h00A5A0 ^ 24'(i);
      host_write(4'(i), exp_cfg[i]);
    end
    for (int i = 0; i < 8; i++) begin
      host_read(4'(i), d);
      check("R6/R7 config readback", d, mask(exp_cfg[i]));
    end
  endtask

  task automatic t_result_ro;
    logic [23:0] d;
    host_write(4'd10, 24'hABCDEF);
    host_read(4'd10, d); check("R8 result write ignored", d, 24'h0);
    host_read(4'd2, d);  check("R8 config untouched", d, mask(exp_cfg[2]));
  endtask

  task automatic t_scan;
    logic [23:0] d, rd;
    int launched = -1;
    for (int i = 0; i < 8; i++) exp_res[i] = 24'h0;
    for (int t = 1; t <= 10; t++) begin
      rd = {12'(12'h500 + t * 3), 12'(12'h100 + t)};
      conv_rdata = rd;
      tick = 1;
      @(negedge clk);
      tick = 0;
      if (launched >= 0) exp_res[launched] = rd;
      launched = (launched + 1) % 8;
      check("R3 strobe high", {23'h0, conv_wstb}, 24'h1);
      check(t == 1 ? "R2 first launch" : (t == 9 ? "R5 wrap launch" : "R4 launch"),
            conv_wdata, mask(exp_cfg[launched]));
      conv_rdata = 24'h777777;
      @(negedge clk);
      check("R3 strobe low", {23'h0, conv_wstb}, 24'h0);
      check("R3 word held", conv_wdata, mask(exp_cfg[launched]));
      if (t == 1) begin
        for (int i = 0; i < 8; i++) begin
          host_read(4'(8 + i), d); check("R2 no capture", d, 24'h0);
        end
      end
    end
    for (int i = 0; i < 8; i++) begin
      host_read(4'(8 + i), d);
      check(i == 7 || i == 0 ? "R5 capture across wrap" : "R4 capture", d, exp_res[i]);
    end
  endtask

  initial begin
    conv_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_config;
    t_result_ro;
    t_scan;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule